// File: doc/BRIEF.md
# Glitchless Clock Output Enable Gate

This block sits between a bank of clock sources and the pad drivers of a clock generator. It takes up to eight source clocks and up to three active-low enable pins. It produces, for each output, a clock value and a drive enable for a tri-state pad. A static configuration sets several things for each output:

- which enable pins control it,
- whether its running clock is inverted,
- the level it holds while stopped: driven low, driven high, or released,
- whether it is permanently unused.

Each output stops and starts only on whole clock phases, so the pad never carries a shortened pulse. The enable pins and a global power-down input are asynchronous. Each output brings them into its own clock domain through a two-flop synchroniser. The output changes state only on the edge chosen for its stopped level:

- the falling edge when the stopped level is low or released,
- the rising edge when the stopped level is high.

When several pins control one output, any pin requesting a stop wins. An output linked to no pin runs whenever it is in use and power-down is inactive.

Top module: `oe_glitchless_gate`

## Requirements
- R1: Output o is controlled by pin i when bit o*P+i of LINK_MAP is set. A controlled output runs while all of its controlling pins are low, and stops while any of them is high.
- R2: An output with no link bits set runs at all times, unless it is unused or power-down is active.
- R3: A pin or power-down change is sampled on two rising edges of the output's phase clock. It then takes effect on the next state-change edge: the falling edge for stopped levels low and released, the rising edge for stopped level high.
- R4: The stopped level is set by the two-bit code at PARK_CODES[2*o+:2]. Code 0 drives low (oe=1, data 0). Code 1 drives high (oe=1, data 1). Code 2 releases the pad (oe=0, data 0).
- R5: When INV_MASK bit o is set, the running output is the complement of its source clock. The stopped level is the same as without inversion.
- R6: When UNUSED_MASK bit o is set, the output has oe=0 and data 0 at all times.
- R7: While power-down is high, every output stops at its state-change edge with oe=0 and data 0. Once power-down is low, outputs return to their pin-controlled behaviour.
- R8: While rst_n is low, every used output shows its configured stopped level.
- R9: While the pad is driven, no high or low phase of an output is shorter than half a period of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | N | Source clock of each output |
| en_pins_n | input | P | Active-low enable pins, asynchronous |
| pwr_dn | input | 1 | Global power-down, high stops all outputs, asynchronous |
| clk_out | output | N | Clock value toward each pad |
| clk_oe | output | N | Drive enable for each pad |

## Verification
A wrong run or power-down flag shows up at the pads within one clock phase. The output then keeps toggling while it should hold its stopped level, or holds a level it should not. A synchroniser with the wrong depth, or a state change on the wrong edge, moves the start or stop by one phase. It can also cut a phase short, and the per-edge reference comparison and the phase-width check on the driven pad report that in the same cycle. Faults in the link decode or in disable dominance show up when an output runs with one of its pins high. They also show up when an unlinked output fails to run.

// File: rtl/oegate_pkg.sv
`timescale 1ns/1ps
package oegate_pkg;
  localparam int MAXP = 8;

  typedef enum logic [1:0] {
    PARK_LOW  = 2'd0,
    PARK_HIGH = 2'd1,
    PARK_HIZ  = 2'd2
  } park_e;

  // all linked pins low -> grant
  function automatic logic pins_grant(input logic [MAXP-1:0] lvl,
                                      input logic [MAXP-1:0] map);
    return ~|(lvl & map);
  endfunction

  function automatic logic park_level(input park_e p);
    return p == PARK_HIGH;
  endfunction

  function automatic logic park_drives(input park_e p);
    return p != PARK_HIZ;
  endfunction
endpackage

// File: rtl/oeg_sync.sv
`timescale 1ns/1ps
module oeg_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/oeg_lane.sv
`timescale 1ns/1ps
module oeg_lane
  import oegate_pkg::*;
#(
  parameter int           P      = 3,
  parameter logic [P-1:0] LINK   = '0,
  parameter bit           INVERT = 1'b0,
  parameter park_e        PARK   = PARK_LOW,
  parameter bit           UNUSED = 1'b0
) (
  input  logic         src_clk,
  input  logic         rst_n,
  input  logic [P-1:0] pins_n,
  input  logic         pwr_dn,
  output logic         clk_out,
  output logic         clk_oe
);
  localparam int SW = P + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {P{1'b1}}};

  logic            ph_clk;
  logic [SW-1:0]   syn;
  logic [MAXP-1:0] pin_ext;
  logic [MAXP-1:0] map_ext;
  logic            want_w;
  logic            pd_w;
  logic            run_q;
  logic            pdz_q;

  generate
    if (INVERT) begin : g_inv
      assign ph_clk = ~src_clk;
    end else begin : g_pass
      assign ph_clk = src_clk;
    end
  endgenerate

  oeg_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (ph_clk),
    .rst_n(rst_n),
    .d    ({pwr_dn, pins_n}),
    .q    (syn)
  );

  always_comb begin
    pin_ext         = '0;
    map_ext         = '0;
    pin_ext[P-1:0]  = syn[P-1:0];
    map_ext[P-1:0]  = LINK;
  end

  assign pd_w   = syn[P];
  assign want_w = pins_grant(pin_ext, map_ext) & ~pd_w;

  generate
    if (PARK == PARK_HIGH) begin : g_rise
      always_ff @(posedge ph_clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= 1'b0;
          pdz_q <= 1'b0;
        end else begin
          run_q <= want_w;
          pdz_q <= pd_w;
        end
      end

      // R1
      run_follow_chk: assert property (@(posedge ph_clk) disable iff (!rst_n)
        (run_q != $past(run_q)) |-> (run_q == $past(want_w)));

      // R9
      full_phase_chk: assert property (@(negedge ph_clk) disable iff (!rst_n)
        (run_q && !UNUSED) |-> clk_out);
    end else begin : g_fall
      always_ff @(negedge ph_clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= 1'b0;
          pdz_q <= 1'b0;
        end else begin
          run_q <= want_w;
          pdz_q <= pd_w;
        end
      end

      // R1
      run_follow_chk: assert property (@(negedge ph_clk) disable iff (!rst_n)
        (run_q != $past(run_q)) |-> (run_q == $past(want_w)));

      // R9
      full_phase_chk: assert property (@(posedge ph_clk) disable iff (!rst_n)
        run_q |-> !clk_out);
    end
  endgenerate

  always_comb begin
    if (UNUSED) begin
      clk_out = 1'b0;
      clk_oe  = 1'b0;
    end else if (run_q) begin
      clk_out = ph_clk;
      clk_oe  = 1'b1;
    end else if (pdz_q) begin
      clk_out = 1'b0;
      clk_oe  = 1'b0;
    end else begin
      clk_out = park_level(PARK);
      clk_oe  = park_drives(PARK);
    end
  end

  // R7
  pd_park_chk: assert property (@(posedge ph_clk) disable iff (!rst_n)
    (pdz_q && !run_q) |-> !clk_oe);

  // R6
  unused_quiet_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    UNUSED |-> !(clk_oe || clk_out));
endmodule

// File: rtl/oe_glitchless_gate.sv
`timescale 1ns/1ps
module oe_glitchless_gate
  import oegate_pkg::*;
#(
  parameter int             N           = 8,
  parameter int             P           = 3,
  parameter logic [N*P-1:0] LINK_MAP    = 24'b000_010_101_100_001_100_100_001,
  parameter logic [N-1:0]   INV_MASK    = 8'b0001_0010,
  parameter logic [N-1:0]   UNUSED_MASK = 8'b0000_1000,
  parameter logic [2*N-1:0] PARK_CODES  = 16'b00_01_10_00_01_10_01_00
) (
  input  logic         rst_n,
  input  logic [N-1:0] src_clk,
  input  logic [P-1:0] en_pins_n,
  input  logic         pwr_dn,
  output logic [N-1:0] clk_out,
  output logic [N-1:0] clk_oe
);
  generate
    for (genvar o = 0; o < N; o++) begin : g_lane
      oeg_lane #(
        .P     (P),
        .LINK  (LINK_MAP[o*P +: P]),
        .INVERT(INV_MASK[o]),
        .PARK  (park_e'(PARK_CODES[2*o +: 2])),
        .UNUSED(UNUSED_MASK[o])
      ) u_lane (
        .src_clk(src_clk[o]),
        .rst_n  (rst_n),
        .pins_n (en_pins_n),
        .pwr_dn (pwr_dn),
        .clk_out(clk_out[o]),
        .clk_oe (clk_oe[o])
      );
    end
  endgenerate
endmodule

// File: tb/oe_glitchless_gate_tb.sv
`timescale 1ns/1ps
module oe_glitchless_gate_tb_top;
  localparam int N = 8;
  localparam int P = 3;
  localparam logic [N*P-1:0] T_LINK   = 24'b000_010_101_100_001_100_100_001;
  localparam logic [N-1:0]   T_INV    = 8'b0001_0010;
  localparam logic [N-1:0]   T_UNUSED = 8'b0000_1000;
  localparam logic [2*N-1:0] T_PARK   = 16'b00_01_10_00_01_10_01_00;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [P-1:0] pins = '1;
  logic         pd = 1'b0;
  logic [N-1:0] clk_out;
  logic [N-1:0] clk_oe;

  int    checks = 0;
  int    fails = 0;
  int    tick = 0;
  string tag = "R8";

  // behavioural per-output model state
  logic [P:0] m_s1 [N];
  logic [P:0] m_s2 [N];
  logic       m_run [N];
  logic       m_pdz [N];
  int         seg_start [N];
  bit         seg_ok [N];
  logic       last_out [N];
  logic       last_oe [N];

  always #2.5 clk = ~clk;

  oe_glitchless_gate #(
    .N(N), .P(P), .LINK_MAP(T_LINK), .INV_MASK(T_INV),
    .UNUSED_MASK(T_UNUSED), .PARK_CODES(T_PARK)
  ) dut_i (
    .rst_n(rst_n), .src_clk(src), .en_pins_n(pins), .pwr_dn(pd),
    .clk_out(clk_out), .clk_oe(clk_oe)
  );

  function automatic int half(input int o);
    return 1 + (o % 3);
  endfunction

  function automatic int park_of(input int o);
    return int'(T_PARK[2*o +: 2]);
  endfunction

  function automatic logic grant(input logic [P:0] s, input int o);
    logic [P-1:0] lk;
    lk = T_LINK[o*P +: P];
    return ((s[P-1:0] & lk) == '0) && !s[P];
  endfunction

  initial begin
    for (int o = 0; o < N; o++) begin
      m_s1[o] = {1'b0, {P{1'b1}}};
      m_s2[o] = {1'b0, {P{1'b1}}};
      m_run[o] = 1'b0;
      m_pdz[o] = 1'b0;
      seg_start[o] = 0;
      seg_ok[o] = 1'b0;
      last_out[o] = 1'b0;
      last_oe[o] = 1'b0;
    end
  end

  // source clocks and model edges
  always @(posedge clk) begin
    tick = tick + 1;
    for (int o = 0; o < N; o++) begin
      if (tick % half(o) == 0) begin
        logic c;
        src[o] = ~src[o];
        c = src[o] ^ T_INV[o];
        if (rst_n) begin
          if (c) begin
            if (park_of(o) == 1) begin
              m_run[o] = grant(m_s2[o], o);
              m_pdz[o] = m_s2[o][P];
            end
            m_s2[o] = m_s1[o];
            m_s1[o] = {pd, pins};
          end else if (park_of(o) != 1) begin
            m_run[o] = grant(m_s2[o], o);
            m_pdz[o] = m_s2[o][P];
          end
        end
      end
    end
  end

  // compare on every clock, away from the source edges
  always @(negedge clk) begin
    for (int o = 0; o < N; o++) begin
      logic eo, ed, c;
      c = src[o] ^ T_INV[o];
      if (T_UNUSED[o]) begin eo = 1'b0; ed = 1'b0; end
      else if (m_run[o]) begin eo = 1'b1; ed = c; end
      else if (m_pdz[o]) begin eo = 1'b0; ed = 1'b0; end
      else begin
        eo = (park_of(o) != 2);
        ed = (park_of(o) == 1);
      end
      checks++;
      if (clk_oe[o] !== eo || clk_out[o] !== ed) begin
        fails++;
        $display("FAIL %s out%0d t=%0d: got oe=%0b d=%0b exp oe=%0b d=%0b",
                 tag, o, tick, clk_oe[o], clk_out[o], eo, ed);
      end
      // R9: phase width while driven
      if (rst_n && (clk_out[o] !== last_out[o] || clk_oe[o] !== last_oe[o])) begin
        if (clk_oe[o] && last_oe[o]) begin
          if (seg_ok[o]) begin
            checks++;
            if (tick - seg_start[o] < half(o)) begin
              fails++;
              $display("FAIL R9 out%0d phase width got %0d exp >= %0d",
                       o, tick - seg_start[o], half(o));
            end
          end
          seg_ok[o] = 1'b1;
        end else begin
          seg_ok[o] = 1'b0;
        end
        seg_start[o] = tick;
      end
      last_out[o] = clk_out[o];
      last_oe[o] = clk_oe[o];
    end
  end

  task automatic chk(input string req, input logic [N-1:0] got,
                     input logic [N-1:0] exp, input logic [N-1:0] mask);
    checks++;
    if ((got & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s explicit: got %b exp %b (mask %b)", req, got, exp, mask);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    // R8 reset state
    tag = "R8";
    step(10);
    @(negedge clk); #0.5;
    chk("R8", clk_oe, 8'b1101_0011, '1);
    chk("R8", clk_out, 8'b0100_0010, '1);
    step(1);
    rst_n = 1'b1;
    // R2 unlinked output runs, others stay parked (R4)
    tag = "R2";
    step(40);
    @(negedge clk); #0.5;
    chk("R4", clk_oe, 8'b1101_0011, 8'b0111_1111);
    step(1);
    // R1 pin0 low: out0 runs, out5 held by pin2 (disable dominant)
    tag = "R1";
    pins = 3'b110;
    step(40);
    @(negedge clk); #0.5;
    chk("R1", clk_oe, 8'b0000_0001, 8'b0010_0001);
    step(1);
    // R5 all of pin0 and pin2 low: inverted outputs 1 and 4 run
    tag = "R5";
    pins = 3'b010;
    step(40);
    @(negedge clk); #0.5;
    chk("R5", clk_oe, 8'b0011_0111, 8'b0011_0111);
    step(1);
    // R1 pin0 high again: out5 and out0 stop
    tag = "R1";
    pins = 3'b011;
    step(40);
    @(negedge clk); #0.5;
    chk("R1", clk_oe, 8'b0001_0011, 8'b0010_0001);
    step(1);
    // R3 pins changing at irregular times
    tag = "R3";
    lfsr = 8'hA5;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pins = lfsr[2:0];
      step(1 + int'(lfsr[6:4]));
    end
    pins = 3'b000;
    step(40);
    // R7 global power-down
    tag = "R7";
    pd = 1'b1;
    step(40);
    @(negedge clk); #0.5;
    chk("R7", clk_oe, '0, '1);
    chk("R7", clk_out, '0, '1);
    step(1);
    pd = 1'b0;
    step(40);
    @(negedge clk); #0.5;
    chk("R7", clk_oe, 8'b1111_0111, '1);
    step(1);
    // R4 all pins high: configured stopped levels, out7 still runs
    tag = "R4";
    pins = 3'b111;
    step(40);
    @(negedge clk); #0.5;
    chk("R4", clk_oe, 8'b0101_0011, 8'b0111_1111);
    chk("R4", clk_out, 8'b0100_0010, 8'b0111_1111);
    chk("R6", {clk_oe[3], clk_out[3], 6'b0}, '0, '1);
    step(1);
    // R6 unused output stays quiet under every pin pattern
    tag = "R6";
    for (int k = 0; k < 8; k++) begin
      pins = 3'(k);
      step(20);
      @(negedge clk); #0.5;
      chk("R6", {clk_oe[3], clk_out[3], 6'b0}, '0, '1);
      step(1);
    end
    finish_run();
  end
endmodule